// File: doc/BRIEF.md
# PCM Frame Strobe Conditioner

This block sits between a serial PCM source and a downstream word sequencer. The source supplies serial data and its bit clock. It also supplies a sync pulse one bit long, which marks the first bit of each minorframe, and an end-of-cycle pulse one word long, which marks the last word of each majorframe. The block assembles each word into a 16-bit parallel value. Around that value it produces a fixed set of strobes that a consumer can rely on without knowing the source's own sync conventions.

The bit clock is repeated to the output unchanged. For every assembled word there is a single-cycle first-bit strobe. A minorframe strobe covers the whole first word of each minorframe, and a majorframe strobe covers the whole first minorframe of each majorframe. The output stream lags the input by one word. A word's strobes and data appear on the clock edge that samples its last serial bit. The word length and the number of words per minorframe are parameters.

Top module: `pcm_strobe_conditioner`

## Requirements
- R1: `bit_clk_out` equals `clk` at all times.
- R2: `first_bit_stb` is high for exactly one cycle per assembled word. It goes high on the edge that samples the word's last bit, so the pulses of back-to-back words are WORD_BITS cycles apart.
- R3: `minor_stb` goes high together with the first-bit strobe of word 0 of a minorframe. It stays high until the next first-bit strobe, which is one word time for continuous frames.
- R4: `major_stb` goes high together with the first-bit strobe of word 0 of a minorframe that follows a minorframe in which `eoc_in` was sampled high. It stays high until the next word-0 strobe, which is one minorframe for continuous frames.
- R5: Serial bits are taken MSB first on the rising edge of `clk`. `par_word` takes the assembled word in the cycle its first-bit strobe is high, and holds it until the next first-bit strobe.
- R6: The assembled word is right-justified in `par_word`, and bits 15 down to WORD_BITS are zero.
- R7: Until the first `fsync_in` pulse is sampled, no strobe is emitted, and `eoc_in` has no effect.
- R8: A sampled `fsync_in` always marks bit 0 of word 0. Any partially assembled word is discarded, and the bit and word counts restart from that point.
- R9: While reset is asserted, and in the cycle after it is released, all strobes are low and `par_word` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Incoming PCM bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_data | input | 1 | Serial PCM data, MSB first |
| fsync_in | input | 1 | Sync pulse one bit long, on the first bit of each minorframe |
| eoc_in | input | 1 | End-of-cycle pulse one word long, on the last word of a majorframe |
| bit_clk_out | output | 1 | Repeated bit clock |
| first_bit_stb | output | 1 | One-cycle strobe per assembled word |
| minor_stb | output | 1 | High for the first word of each minorframe |
| major_stb | output | 1 | High for the first minorframe of each majorframe |
| par_word | output | 16 | Right-justified parallel word |

## Verification
The bench first streams data with no sync pulse. A design that locks early would emit strobes with no expected item queued, and those are reported. A majorframe ends with an end-of-cycle word, and the strobe must move to the following minorframe. A design that looked at the pulse itself rather than latching it would put `major_stb` on the wrong frame, or drop it. Data patterns with only the top or only the bottom bit set expose a reversed shift order or a bad pad in the upper bits. A sync pulse arriving in the middle of a word checks that a design which ignores re-alignment does not keep emitting words on the stale boundary.

// File: rtl/pcm_sc_pkg.sv
package pcm_sc_pkg;
    localparam int PAR_W = 16;

    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/pcm_word_tracker.sv
module pcm_word_tracker
    import pcm_sc_pkg::*;
#(
    parameter int WORD_BITS       = 8,
    parameter int WORDS_PER_MINOR = 4,
    parameter int BIT_W           = cnt_width(WORD_BITS),
    parameter int WRD_W           = cnt_width(WORDS_PER_MINOR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync_in,
    output logic             active_o,
    output logic             word_end_o,
    output logic [WRD_W-1:0] word_idx_o
);
    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(WORD_BITS - 1);
    localparam logic [WRD_W-1:0] LAST_WORD = WRD_W'(WORDS_PER_MINOR - 1);

    typedef struct packed {
        logic             locked;
        logic [BIT_W-1:0] bit_cnt;
        logic [WRD_W-1:0] word_cnt;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [BIT_W-1:0] cur_bit;
    logic [WRD_W-1:0] cur_word;
    logic             active;
    logic             word_end;

    always_comb begin
        active   = trk_q.locked | fsync_in;
        cur_bit  = fsync_in ? '0 : trk_q.bit_cnt;
        cur_word = fsync_in ? '0 : trk_q.word_cnt;
        word_end = active && (cur_bit == LAST_BIT);

        trk_d = trk_q;
        if (!active) begin
            trk_d.bit_cnt  = '0;
            trk_d.word_cnt = '0;
        end else begin
            trk_d.locked = 1'b1;
            if (word_end) begin
                trk_d.bit_cnt  = '0;
                trk_d.word_cnt = (cur_word == LAST_WORD) ? '0 : cur_word + 1'b1;
            end else begin
                trk_d.bit_cnt  = cur_bit + 1'b1;
                trk_d.word_cnt = cur_word;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign active_o   = active;
    assign word_end_o = word_end;
    assign word_idx_o = cur_word;
endmodule

// File: rtl/pcm_word_shifter.sv
module pcm_word_shifter
    import pcm_sc_pkg::*;
#(
    parameter int WORD_BITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_data,
    input  logic             word_end,
    output logic [PAR_W-1:0] par_o
);
    typedef struct packed {
        logic [WORD_BITS-2:0] shift;
        logic [PAR_W-1:0]     par;
    } shf_t;

    shf_t shf_d, shf_q;
    logic [PAR_W-1:0] ext;

    always_comb begin
        ext                = '0;
        ext[WORD_BITS-1:0] = {shf_q.shift, ser_data};

        shf_d       = shf_q;
        shf_d.shift = (WORD_BITS-1)'({shf_q.shift, ser_data});
        if (word_end) shf_d.par = ext;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= shf_d;
    end

    assign par_o = shf_q.par;
endmodule

// File: rtl/pcm_frame_strobes.sv
module pcm_frame_strobes
    import pcm_sc_pkg::*;
#(
    parameter int WRD_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             word_end,
    input  logic [WRD_W-1:0] word_idx,
    input  logic             eoc_in,
    output logic             first_bit_o,
    output logic             minor_o,
    output logic             major_o
);
    typedef struct packed {
        logic first_bit;
        logic minor;
        logic major;
        logic eoc_seen;
    } stb_t;

    stb_t stb_d, stb_q;
    logic at_word0;

    always_comb begin
        at_word0        = word_end && (word_idx == '0);
        stb_d           = stb_q;
        stb_d.first_bit = word_end;
        if (word_end) stb_d.minor = (word_idx == '0);
        if (at_word0) stb_d.major = stb_q.eoc_seen;
        if (active) begin
            if (at_word0) stb_d.eoc_seen = eoc_in;
            else          stb_d.eoc_seen = stb_q.eoc_seen | eoc_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= '0;
        else        stb_q <= stb_d;
    end

    assign first_bit_o = stb_q.first_bit;
    assign minor_o     = stb_q.minor;
    assign major_o     = stb_q.major;
endmodule

// File: rtl/pcm_strobe_conditioner.sv
module pcm_strobe_conditioner
    import pcm_sc_pkg::*;
#(
    parameter int WORD_BITS       = 8,
    parameter int WORDS_PER_MINOR = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_data,
    input  logic             fsync_in,
    input  logic             eoc_in,
    output logic             bit_clk_out,
    output logic             first_bit_stb,
    output logic             minor_stb,
    output logic             major_stb,
    output logic [PAR_W-1:0] par_word
);
    localparam int WRD_W = cnt_width(WORDS_PER_MINOR);

    logic             active;
    logic             word_end;
    logic [WRD_W-1:0] word_idx;

    initial begin
        assert (WORD_BITS >= 2 && WORD_BITS <= PAR_W)
            else $error("WORD_BITS out of range");
    end

    assign bit_clk_out = clk;

    pcm_word_tracker #(
        .WORD_BITS(WORD_BITS),
        .WORDS_PER_MINOR(WORDS_PER_MINOR)
    ) u_trk (
        .clk(clk), .rst_n(rst_n), .fsync_in(fsync_in),
        .active_o(active), .word_end_o(word_end), .word_idx_o(word_idx)
    );

    pcm_word_shifter #(.WORD_BITS(WORD_BITS)) u_shf (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data),
        .word_end(word_end), .par_o(par_word)
    );

    pcm_frame_strobes #(.WRD_W(WRD_W)) u_stb (
        .clk(clk), .rst_n(rst_n), .active(active), .word_end(word_end),
        .word_idx(word_idx), .eoc_in(eoc_in),
        .first_bit_o(first_bit_stb), .minor_o(minor_stb), .major_o(major_stb)
    );
endmodule

// File: rtl/pcm_strobe_conditioner_chk.sv
module pcm_strobe_conditioner_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        fsync_in,
    input logic        first_bit_stb,
    input logic        minor_stb,
    input logic        major_stb,
    input logic [15:0] par_word
);
    logic seen_sync_q;

    always_ff @(posedge clk) begin
        if (!rst_n)        seen_sync_q <= 1'b0;
        else if (fsync_in) seen_sync_q <= 1'b1;
    end

    p_fb_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        first_bit_stb |=> !first_bit_stb);

    p_minor_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(minor_stb) |-> first_bit_stb);

    p_minor_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(minor_stb) |-> first_bit_stb);

    p_major_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(major_stb) |-> (first_bit_stb && minor_stb));

    p_par_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !first_bit_stb |-> $stable(par_word));

    p_quiet_unlocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_sync_q |-> !(first_bit_stb || minor_stb || major_stb));
endmodule

bind pcm_strobe_conditioner pcm_strobe_conditioner_chk u_chk (
    .clk(clk), .rst_n(rst_n), .fsync_in(fsync_in),
    .first_bit_stb(first_bit_stb), .minor_stb(minor_stb),
    .major_stb(major_stb), .par_word(par_word)
);

// File: tb/pcm_strobe_conditioner_tb_top.sv
module pcm_strobe_conditioner_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WB  = 8;
    localparam int WPM = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_data = 1'b0;
    logic fsync_in = 1'b0;
    logic eoc_in = 1'b0;
    logic bit_clk_out, first_bit_stb, minor_stb, major_stb;
    logic [15:0] par_word;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_strobe_conditioner #(.WORD_BITS(WB), .WORDS_PER_MINOR(WPM)) dut_i (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .fsync_in(fsync_in),
        .eoc_in(eoc_in), .bit_clk_out(bit_clk_out), .first_bit_stb(first_bit_stb),
        .minor_stb(minor_stb), .major_stb(major_stb), .par_word(par_word)
    );

    typedef struct packed {
        logic [15:0] data;
        logic        minor;
        logic        major;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;
    logic have_cur = 1'b0;
    logic mon_on = 1'b0;
    int   n_chk = 0;
    int   n_bad = 0;
    int   fb_count = 0;
    logic maj_next = 1'b0;
    logic cur_major = 1'b0;
    logic finished = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // Driver: one word, MSB first; pushes the expected output item.
    task automatic send_word(input logic [WB-1:0] val, input int widx,
                             input logic eoc, input logic push);
        exp_t e;
        for (int b = WB - 1; b >= 0; b--) begin
            @(posedge clk); #1;
            ser_data = val[b];
            fsync_in = (widx == 0 && b == WB - 1) ? 1'b1 : 1'b0;
            eoc_in   = eoc;
        end
        if (push) begin
            if (widx == 0) begin
                cur_major = maj_next;
                maj_next  = 1'b0;
            end
            if (eoc) maj_next = 1'b1;
            e.data  = {{(16-WB){1'b0}}, val};
            e.minor = (widx == 0);
            e.major = cur_major;
            exp_q.push_back(e);
        end
    endtask

    task automatic send_frame(input logic [WB-1:0] base, input logic eoc_last);
        for (int w = 0; w < WPM; w++)
            send_word(base + WB'(w * 37), w, eoc_last && (w == WPM - 1), 1'b1);
    endtask

    // Monitor: compares at the falling edge.
    always @(negedge clk) begin
        if (mon_on) begin
            if (first_bit_stb) begin
                fb_count++;
                if (exp_q.size() == 0) begin
                    n_chk++; n_bad++;
                    $display("FAIL R2 unexpected first-bit strobe actual=1 expected=0");
                end else begin
                    cur = exp_q.pop_front();
                    have_cur = 1'b1;
                    check("R5 word value", par_word, cur.data);
                    check("R6 upper bits zero", par_word[15:WB], '0);
                    check("R3 minor strobe", minor_stb, cur.minor);
                    check("R4 major strobe", major_stb, cur.major);
                end
            end else if (have_cur) begin
                check("R5 word hold", par_word, cur.data);
                check("R3 minor hold", minor_stb, cur.minor);
                check("R4 major hold", major_stb, cur.major);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
    end

    initial begin
        // R9: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R9 fb in reset", first_bit_stb, 0);
        check("R9 minor in reset", minor_stb, 0);
        check("R9 major in reset", major_stb, 0);
        check("R9 par in reset", par_word, 0);
        @(negedge clk);
        check("R1 bit clock low", bit_clk_out, clk);
        @(posedge clk); #1;
        check("R1 bit clock high", bit_clk_out, 1);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R9 fb after release", first_bit_stb, 0);
        check("R9 par after release", par_word, 0);
        mon_on = 1'b1;

        // R7: data and end-of-cycle with no sync
        for (int i = 0; i < 27; i++) begin
            @(posedge clk); #1;
            ser_data = i[0] ^ i[2];
            eoc_in   = (i > 10 && i < 19);
        end
        eoc_in = 1'b0;
        @(negedge clk);
        check("R7 no strobes before sync", fb_count, 0);

        // R2 R3 R4: one majorframe of three minorframes, then the next majorframe
        send_frame(8'h11, 1'b0);
        send_frame(8'h80, 1'b0);
        send_frame(8'h01, 1'b1);
        send_frame(8'hFF, 1'b0);
        send_frame(8'h00, 1'b0);

        // R8: sync mid-frame after a partial word
        send_word(8'hA5, 0, 1'b0, 1'b1);
        send_word(8'h5A, 1, 1'b0, 1'b1);
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            ser_data = 1'b1; fsync_in = 1'b0;
        end
        send_frame(8'h3C, 1'b1);
        send_frame(8'hC3, 1'b0);

        while (exp_q.size() != 0) @(negedge clk);
        @(posedge clk); #1;
        mon_on = 1'b0;
        check("R2 all words delivered", exp_q.size(), 0);
        check("R2 strobe count", fb_count, 5 * WPM + 2 + 2 * WPM);
        summary();
    end
endmodule